// File: doc/BRIEF.md
# Physical Address Cacheability Classifier

This block sits right after address translation. It takes a translated physical address and a flag that says whether the access is an instruction fetch. In the same cycle it decides three things: whether the address fits the implemented physical range, whether it points into uncached space, and whether the access may be issued at all.

Uncached space is marked by a single high address bit. An access that carries this bit is flagged as uncacheable and strictly ordered. A field of address bits just below the marker is then zeroed before the address goes on. The high bit itself is kept.

Two kinds of uncached access are refused:
- An uncached address that hits the internal-register window is refused with the unimplemented code.
- An instruction fetch that lands in uncached space is refused with the same code. Fetching from a device register could destroy data that clears when it is read.

Any address bit above the implemented width raises a machine check. This check is made before any of the others.

The logic is purely combinational. It has no clock and no reset.

Top module: `pa_cache_classifier`

## Requirements
- R1: If any address bit at or above position 44 is set, `faultCode` is 2'b01 (machine check). This holds whatever the value of bit 43, the register-window field and `isFetch`.
- R2: With bits 63:44 clear, bit 43 set and the register-window field (bits 42:41) not equal to 2'b11, a data access (`isFetch`=0) gives `faultCode` 2'b00, `uncacheable`=1 and `strictOrder`=1.
- R3: For the access of R2, `outAddr` equals `physAddr` with bits 42:35 forced to zero. Every other bit, including bit 43, passes through unchanged.
- R4: With bits 63:44 clear, bit 43 set and bits 42:41 equal to 2'b11, `faultCode` is 2'b10 (unimplemented). This holds for both fetch and data accesses.
- R5: An instruction fetch (`isFetch`=1) with bits 63:44 clear, bit 43 set and bits 42:41 not 2'b11 gives `faultCode` 2'b10.
- R6: With bits 63:43 all clear, `faultCode` is 2'b00, `uncacheable`=0, `strictOrder`=0 and `outAddr` equals `physAddr`. This holds for both fetch and data accesses.
- R7: `uncacheable` and `strictOrder` are always equal. When `faultCode` is not 2'b00, `outAddr` and both flags carry no meaning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| physAddr | input | 64 | Translated physical address |
| isFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| outAddr | output | 64 | Address to issue, with the uncached field cleaned |
| uncacheable | output | 1 | The access must bypass the caches |
| strictOrder | output | 1 | The access must be neither reordered nor speculated |
| faultCode | output | 2 | 00 = none, 01 = machine check, 10 = unimplemented |

## Verification
The block holds no state, so a wrong internal decision shows up at the ports as soon as the inputs settle.

If the range test, the marker decode or the register-window compare is wrong, `faultCode` or the flag pair takes the wrong value for that same address. A wrong clear mask shows as corrupted bits 42:35 on `outAddr`.

The directed cases put set bits both inside and just outside every field boundary, so an error of one position in any field is visible.

// File: rtl/pa_class_pkg.sv
package pa_class_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE   = 2'b00,
    FAULT_MCHECK = 2'b01,
    FAULT_UNIMP  = 2'b10
  } fault_e;

  // Strobes sent by the control unit to the datapath
  typedef struct packed {
    logic stripField;
    logic markUncached;
  } ctl_strobe_t;

endpackage

// File: rtl/pa_class_datapath.sv
module pa_class_datapath
  import pa_class_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int IMPL_W    = 44,
  parameter int UC_BIT    = 43,
  parameter int CLR_HI    = 42,
  parameter int CLR_LO    = 35,
  parameter int WIN_HI    = 42,
  parameter int WIN_LO    = 41,
  parameter logic [WIN_HI-WIN_LO:0] WIN_VAL = '1
) (
  input  logic [ADDR_W-1:0] physAddr,
  input  ctl_strobe_t       strobes,
  output logic              overRange,
  output logic              ucMarked,
  output logic              regWindow,
  output logic [ADDR_W-1:0] outAddr,
  output logic              uncacheable,
  output logic              strictOrder
);

  localparam logic [ADDR_W-1:0] IMPL_MASK = (ADDR_W'(1) << IMPL_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CLR_MASK =
    ((ADDR_W'(1) << (CLR_HI + 1)) - ADDR_W'(1)) & ~((ADDR_W'(1) << CLR_LO) - ADDR_W'(1));

  always_comb begin
    overRange = |(physAddr & ~IMPL_MASK);
    ucMarked  = physAddr[UC_BIT];
    regWindow = (physAddr[WIN_HI:WIN_LO] == WIN_VAL);
  end

  always_comb begin
    outAddr     = strobes.stripField ? (physAddr & ~CLR_MASK) : physAddr;
    uncacheable = strobes.markUncached;
    strictOrder = strobes.markUncached;
  end

  // R3: a cleaned address keeps every bit outside the cleared field
  always_comb begin
    if (strobes.stripField) begin
      assert_strip_keeps_rest_R3: assert ((outAddr & ~CLR_MASK) == (physAddr & ~CLR_MASK));
    end
  end

  // R7: the two flags never differ
  always_comb begin
    assert_flags_paired_R7: assert (uncacheable == strictOrder);
  end

endmodule

// File: rtl/pa_class_control.sv
module pa_class_control
  import pa_class_pkg::*;
(
  input  logic        overRange,
  input  logic        ucMarked,
  input  logic        regWindow,
  input  logic        isFetch,
  output ctl_strobe_t strobes,
  output fault_e      faultCode
);

  always_comb begin
    strobes   = '0;
    faultCode = FAULT_NONE;
    if (overRange) begin
      faultCode = FAULT_MCHECK;
    end else if (ucMarked) begin
      if (regWindow) begin
        faultCode = FAULT_UNIMP;
      end else begin
        strobes.markUncached = 1'b1;
        strobes.stripField   = 1'b1;
        if (isFetch) faultCode = FAULT_UNIMP;
      end
    end
  end

  // R1: an out-of-range address always reports a machine check
  always_comb begin
    if (overRange) begin
      assert_mcheck_first_R1: assert (faultCode == FAULT_MCHECK);
    end
  end

  // R5: a fetch is never allowed to be issued as uncached
  always_comb begin
    if (isFetch && strobes.markUncached) begin
      assert_no_uc_fetch_R5: assert (faultCode == FAULT_UNIMP);
    end
  end

  // R6: an address without the marker is never treated as uncached
  always_comb begin
    if (!ucMarked) begin
      assert_plain_cached_R6: assert (strobes == '0);
    end
  end

endmodule

// File: rtl/pa_cache_classifier.sv
module pa_cache_classifier
  import pa_class_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMPL_W = 44,
  parameter int UC_BIT = 43,
  parameter int CLR_HI = 42,
  parameter int CLR_LO = 35,
  parameter int WIN_HI = 42,
  parameter int WIN_LO = 41,
  parameter logic [WIN_HI-WIN_LO:0] WIN_VAL = '1
) (
  input  logic [ADDR_W-1:0] physAddr,
  input  logic              isFetch,
  output logic [ADDR_W-1:0] outAddr,
  output logic              uncacheable,
  output logic              strictOrder,
  output logic [1:0]        faultCode
);

  ctl_strobe_t strobes;
  fault_e      faultSel;
  logic        overRange;
  logic        ucMarked;
  logic        regWindow;

  pa_class_datapath #(
    .ADDR_W(ADDR_W), .IMPL_W(IMPL_W), .UC_BIT(UC_BIT),
    .CLR_HI(CLR_HI), .CLR_LO(CLR_LO),
    .WIN_HI(WIN_HI), .WIN_LO(WIN_LO), .WIN_VAL(WIN_VAL)
  ) u_datapath (
    .physAddr   (physAddr),
    .strobes    (strobes),
    .overRange  (overRange),
    .ucMarked   (ucMarked),
    .regWindow  (regWindow),
    .outAddr    (outAddr),
    .uncacheable(uncacheable),
    .strictOrder(strictOrder)
  );

  pa_class_control u_control (
    .overRange(overRange),
    .ucMarked (ucMarked),
    .regWindow(regWindow),
    .isFetch  (isFetch),
    .strobes  (strobes),
    .faultCode(faultSel)
  );

  assign faultCode = faultSel;

  // R2/R4: at the top level, a clean result never carries the window or a fetch
  always_comb begin
    if (uncacheable && faultCode == 2'b00) begin
      assert_clean_uc_data_R2: assert (!isFetch);
    end
  end

endmodule

// File: tb/pa_cache_classifier_bench.sv
module pa_cache_classifier_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] physAddr = '0;
  logic        isFetch = 1'b0;
  logic [63:0] outAddr;
  logic        uncacheable, strictOrder;
  logic [1:0]  faultCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [63:0] CLRF = 64'h0000_07F8_0000_0000; // bits 42:35
  localparam logic [63:0] UCB  = 64'h0000_0800_0000_0000; // bit 43

  always #2 clk = ~clk;

  pa_cache_classifier u_pa_cache_classifier (
    .physAddr(physAddr), .isFetch(isFetch), .outAddr(outAddr),
    .uncacheable(uncacheable), .strictOrder(strictOrder), .faultCode(faultCode)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic f);
    @(negedge clk);
    physAddr = a;
    isFetch  = f;
    #1;
  endtask

  task automatic t_reset_state;
    apply(64'h0, 1'b0);
    chk("R6 reset fault", 64'(faultCode), 64'd0);
    chk("R6 reset addr", outAddr, 64'h0);
    chk("R6 reset flags", {62'd0, uncacheable, strictOrder}, 64'd0);
  endtask

  task automatic t_machine_check;
    apply(64'h0000_1000_0000_0000, 1'b0);  // bit 44 only
    chk("R1 bit44", 64'(faultCode), 64'd1);
    apply(64'h8000_0000_0000_0000, 1'b1);
    chk("R1 bit63 fetch", 64'(faultCode), 64'd1);
    apply(64'h0000_1E00_0000_0000, 1'b0);  // over range + uc + window
    chk("R1 precedence over window", 64'(faultCode), 64'd1);
  endtask

  task automatic t_uncached_data;
    logic [63:0] a;
    a = UCB | 64'h0000_05FF_FFFF_FFFF;     // window bits 42:41 = 10
    apply(a, 1'b0);
    chk("R2 fault", 64'(faultCode), 64'd0);
    chk("R2 uncacheable", 64'(uncacheable), 64'd1);
    chk("R7 strictOrder", 64'(strictOrder), 64'd1);
    chk("R3 strip", outAddr, a & ~CLRF);
    a = UCB | 64'h0000_0207_FFFF_FFFF;     // window 01, bits 34:0 set
    apply(a, 1'b0);
    chk("R3 strip keeps low", outAddr, UCB | 64'h0000_0007_FFFF_FFFF);
  endtask

  task automatic t_reg_window;
    apply(UCB | 64'h0000_0600_0000_1234, 1'b0);
    chk("R4 window data", 64'(faultCode), 64'd2);
    apply(UCB | 64'h0000_0600_0000_0000, 1'b1);
    chk("R4 window fetch", 64'(faultCode), 64'd2);
  endtask

  task automatic t_uncached_fetch;
    apply(UCB | 64'h0000_0000_0000_0040, 1'b1);
    chk("R5 uc fetch", 64'(faultCode), 64'd2);
  endtask

  task automatic t_cached;
    apply(64'h0000_07FF_FFFF_FFFF, 1'b0);
    chk("R6 cached data fault", 64'(faultCode), 64'd0);
    chk("R6 cached data addr", outAddr, 64'h0000_07FF_FFFF_FFFF);
    chk("R6 cached data flags", {62'd0, uncacheable, strictOrder}, 64'd0);
    apply(64'h0000_0123_4567_89A0, 1'b1);
    chk("R6 cached fetch fault", 64'(faultCode), 64'd0);
    chk("R6 cached fetch addr", outAddr, 64'h0000_0123_4567_89A0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_machine_check();
    t_uncached_data();
    t_reg_window();
    t_uncached_fetch();
    t_cached();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 10000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule